// File: doc/BRIEF.md
# Stack and Call Vector Controller

This block owns the 8-bit stack pointer of a small processor core and performs every operation that moves data between the core and its stack. The stack always lives in memory page 0x01. The block also works out the target of each subroutine entry. The core issues one command with a single-cycle `start` pulse. Commands are byte push and pop, word push and pop, status-byte pop, absolute call, page call, vector-table call and break. The block then drives a byte-wide synchronous memory port, one access per cycle, until the command is complete.

When a command finishes, `done` pulses for one cycle. In that same cycle `busy` drops and the results become valid: the new program counter on `pc_out`, the popped value on `pop_data`, and the updated `sp`. Table calls and break fetch a 16-bit little-endian target from a 16-entry vector table at the top of memory. The table is indexed from its high end downward. Popping the status byte also reselects the direct-page base, which appears on `dp_base`. Instruction decode, flag arithmetic and the program counter register itself belong to the surrounding core.

Top module: `stk_call_ctrl`

## Requirements
- R1: After reset, `sp` is 0xFF, `dp_base` is 0x0000, `pc_out` is 0x0000, and both `busy` and `done` are low.
- R2: Byte push (cmd 0) writes `arg[7:0]` to 0x0100+S and then S becomes S-1. Byte pop (cmd 1) sets S to S+1 and reads 0x0100+S, and the byte appears on `pop_data[7:0]` with `pop_data[15:8]` zero.
- R3: Word push (cmd 2) writes `arg[7:0]` to 0x0100+((S-1) mod 256) and `arg[15:8]` to 0x0100+S, and then S becomes S-2. Word pop (cmd 3) sets S to S+2 and returns {mem[0x0100+S], mem[0x0100+((S-1) mod 256)]} on `pop_data`.
- R4: The stack pointer wraps modulo 256, and every stack write has upper address byte 0x01, including a word push made at S=0x00.
- R5: Absolute call (cmd 5) pushes `pc_in`+3 as a word in the same way as R3 and sets `pc_out` to `arg`.
- R6: Page call (cmd 6) pushes `pc_in`+2 as a word and sets `pc_out` to 0xFF00 | `arg[7:0]`. Bits `arg[15:8]` have no effect.
- R7: Table call (cmd 7) with n=`arg[3:0]` pushes `pc_in`+1 as a word. It then reads the low byte of the target from 0xFFC0+(15-n)*2 and the high byte from the next address, and drives the target on `pc_out`.
- R8: Break (cmd 8) pushes `pc_in`+1 as a word. It then writes `psw_in` at the next lower stack slot, leaving S reduced by 3, and loads `pc_out` from the vector at 0xFFDE/0xFFDF (the same entry as table call 0).
- R9: Status pop (cmd 4) behaves as a byte pop. It also sets `dp_base` to 0x0100 when bit 5 of the popped byte is 1 and to 0x0000 otherwise. No other command changes `dp_base`.
- R10: The port never reads and writes in the same cycle. The number of `busy` cycles equals the number of memory accesses, with one extra cycle for a capture: byte push 1, byte pop 2, word push 2, word pop 3, absolute or page call 2, table call 5, break 6. `done` is a one-cycle pulse with `busy` low.
- R11: A `start` pulse that arrives while `busy` is high is ignored. It causes no memory access and no change of `sp` or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when not busy |
| cmd | input | 4 | Command code (see requirements) |
| arg | input | 16 | Push data, call target, page offset or table index |
| pc_in | input | 16 | Program counter of the issuing instruction |
| psw_in | input | 8 | Packed status byte for break |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter after a call or break |
| pop_data | output | 16 | Value returned by the last pop |
| sp | output | 8 | Stack pointer |
| dp_base | output | 16 | Direct-page base address |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The hardest situations to reach are the word accesses that straddle the pointer wrap. In these the low byte sits at 0x01FF while the high byte sits at 0x0100, or the reverse happens on a pop. The stimulus reaches them without back-door access. It pops from the reset value 0xFF so that S wraps to 0x00, then pushes a word there and pops it back. A second hard case is a `start` strobe delivered in mid-command. The bench raises it on the cycle after a table call is accepted and confirms that the write count, the pointer and the target all remain those of the table call.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [3:0] {
      CMD_PUSH_B    = 4'd0,
      CMD_POP_B     = 4'd1,
      CMD_PUSH_W    = 4'd2,
      CMD_POP_W     = 4'd3,
      CMD_POP_PSW   = 4'd4,
      CMD_CALL_ABS  = 4'd5,
      CMD_CALL_PAGE = 4'd6,
      CMD_CALL_TBL  = 4'd7,
      CMD_BRK       = 4'd8
   } stk_cmd_e;

   localparam logic [3:0] CMD_LAST = 4'd8;

   // WB byte write, WL/WH word low/high write, WP status write,
   // RB/RBE byte read and capture, RL/RH/RE word read steps,
   // VL/VH/VE vector read steps
   typedef enum logic [3:0] {
      ST_IDLE, ST_WB, ST_WL, ST_WH, ST_WP,
      ST_RB, ST_RBE, ST_RL, ST_RH, ST_RE,
      ST_VL, ST_VH, ST_VE
   } stk_state_e;

endpackage

// File: rtl/stk_sp.sv
module stk_sp #(
   parameter int               SP_W     = 8,
   parameter logic [SP_W-1:0]  SP_RESET = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  logic [SP_W-1:0] step,
   output logic [SP_W-1:0] sp
);

   localparam logic [SP_W-1:0] D_P1 = SP_W'(1);
   localparam logic [SP_W-1:0] D_P2 = SP_W'(2);
   localparam logic [SP_W-1:0] D_M1 = '1;
   localparam logic [SP_W-1:0] D_M2 = ~SP_W'(1);

   generate
      if (SP_W < 2) begin : g_bad_width
         $error("stk_sp: SP_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       sp <= SP_RESET;
      else if (step_en) sp <= sp + step;
   end

   // pointer only ever moves by one or two slots, wrapping in its width
   assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sp) |-> ((sp - $past(sp)) == D_P1 || (sp - $past(sp)) == D_P2 ||
                        (sp - $past(sp)) == D_M1 || (sp - $past(sp)) == D_M2));

endmodule

// File: rtl/stk_addr.sv
module stk_addr
   import stk_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SP_W       = 8,
   parameter int STACK_PAGE = 1,
   parameter int VEC_BASE   = 'hFFC0,
   parameter int VEC_N      = 16,
   parameter bit PAGE_WRAP  = 1'b1,
   localparam int IDX_W     = $clog2(VEC_N),
   localparam int PAGE_W    = ADDR_W - SP_W
) (
   input  stk_state_e       state,
   input  logic [SP_W-1:0]  sp,
   input  logic [IDX_W-1:0] vec_idx,
   output logic [ADDR_W-1:0] mem_addr
);

   localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(STACK_PAGE);
   localparam logic [ADDR_W-1:0] VBASE = ADDR_W'(VEC_BASE);

   logic [SP_W-1:0]   sp_inc, sp_dec;
   logic [ADDR_W-1:0] a_top, a_next, a_low, v_lo, v_hi;
   logic [IDX_W-1:0]  rev;

   assign sp_inc = sp + SP_W'(1);
   assign sp_dec = sp - SP_W'(1);
   assign a_top  = {PAGE, sp};
   assign a_next = {PAGE, sp_inc};
   assign rev    = IDX_W'(VEC_N - 1) - vec_idx;
   assign v_lo   = VBASE + ADDR_W'({rev, 1'b0});
   assign v_hi   = v_lo + ADDR_W'(1);

   // low byte of a word slot: kept in the page, or plain linear minus one
   generate
      if (PAGE_WRAP) begin : g_wrap
         assign a_low = {PAGE, sp_dec};
      end else begin : g_linear
         assign a_low = a_top - ADDR_W'(1);
      end
   endgenerate

   always_comb begin
      case (state)
         ST_WB, ST_WH, ST_WP, ST_RH: mem_addr = a_top;
         ST_WL:                      mem_addr = a_low;
         ST_RB, ST_RL:               mem_addr = a_next;
         ST_VL:                      mem_addr = v_lo;
         ST_VH:                      mem_addr = v_hi;
         default:                    mem_addr = '0;
      endcase
   end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SP_W         = 8,
   parameter int VEC_N        = 16,
   parameter int PAGE_BASE    = 'hFF00,
   parameter int DP_FLAG_BIT  = 5,
   parameter int DP_HIGH_BASE = 'h0100,
   localparam int ADDR_W      = 2 * DATA_W,
   localparam int IDX_W       = $clog2(VEC_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        cmd,
   input  logic [ADDR_W-1:0] arg,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] psw_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output stk_state_e        state,
   output logic [IDX_W-1:0]  vec_idx,
   output logic              sp_en,
   output logic [SP_W-1:0]   sp_step,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] pop_data,
   output logic [ADDR_W-1:0] dp_base
);

   stk_cmd_e          cmd_q;
   logic [ADDR_W-1:0] wword_q, tgt_q;
   logic [DATA_W-1:0] bval_q, psw_q, lo_q;

   // ---------------- access decode ----------------
   always_comb begin
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_wdata = '0;
      sp_en     = 1'b0;
      sp_step   = '0;
      case (state)
         ST_WB: begin
            mem_we = 1'b1; mem_wdata = bval_q;
            sp_en  = 1'b1; sp_step   = '1;
         end
         ST_WL: begin
            mem_we = 1'b1; mem_wdata = wword_q[DATA_W-1:0];
         end
         ST_WH: begin
            mem_we = 1'b1; mem_wdata = wword_q[ADDR_W-1:DATA_W];
            sp_en  = 1'b1; sp_step   = ~SP_W'(1);
         end
         ST_WP: begin
            mem_we = 1'b1; mem_wdata = psw_q;
            sp_en  = 1'b1; sp_step   = '1;
         end
         ST_RB: begin
            mem_re = 1'b1; sp_en = 1'b1; sp_step = SP_W'(1);
         end
         ST_RL: begin
            mem_re = 1'b1; sp_en = 1'b1; sp_step = SP_W'(2);
         end
         ST_RH, ST_VL, ST_VH: mem_re = 1'b1;
         default: ;
      endcase
   end

   assign busy = (state != ST_IDLE);

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cmd_q    <= CMD_PUSH_B;
         wword_q  <= '0;
         tgt_q    <= '0;
         bval_q   <= '0;
         psw_q    <= '0;
         lo_q     <= '0;
         vec_idx  <= '0;
         done     <= 1'b0;
         pc_out   <= '0;
         pop_data <= '0;
         dp_base  <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start && cmd <= CMD_LAST) begin
                  cmd_q <= stk_cmd_e'(cmd);
                  case (stk_cmd_e'(cmd))
                     CMD_PUSH_B: begin
                        bval_q <= arg[DATA_W-1:0];
                        state  <= ST_WB;
                     end
                     CMD_POP_B, CMD_POP_PSW: state <= ST_RB;
                     CMD_PUSH_W: begin
                        wword_q <= arg;
                        state   <= ST_WL;
                     end
                     CMD_POP_W: state <= ST_RL;
                     CMD_CALL_ABS: begin
                        wword_q <= pc_in + ADDR_W'(3);
                        tgt_q   <= arg;
                        state   <= ST_WL;
                     end
                     CMD_CALL_PAGE: begin
                        wword_q <= pc_in + ADDR_W'(2);
                        tgt_q   <= ADDR_W'(PAGE_BASE) | ADDR_W'(arg[DATA_W-1:0]);
                        state   <= ST_WL;
                     end
                     CMD_CALL_TBL: begin
                        wword_q <= pc_in + ADDR_W'(1);
                        vec_idx <= arg[IDX_W-1:0];
                        state   <= ST_WL;
                     end
                     default: begin
                        wword_q <= pc_in + ADDR_W'(1);
                        psw_q   <= psw_in;
                        vec_idx <= '0;
                        state   <= ST_WL;
                     end
                  endcase
               end
            end
            ST_WB: begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            ST_WL: state <= ST_WH;
            ST_WH: begin
               case (cmd_q)
                  CMD_CALL_TBL: state <= ST_VL;
                  CMD_BRK:      state <= ST_WP;
                  CMD_CALL_ABS, CMD_CALL_PAGE: begin
                     pc_out <= tgt_q;
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                  end
                  default: begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end
               endcase
            end
            ST_WP:  state <= ST_VL;
            ST_RB:  state <= ST_RBE;
            ST_RBE: begin
               pop_data <= ADDR_W'(mem_rdata);
               if (cmd_q == CMD_POP_PSW)
                  dp_base <= mem_rdata[DP_FLAG_BIT] ? ADDR_W'(DP_HIGH_BASE) : '0;
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            ST_RL: state <= ST_RH;
            ST_RH: begin
               lo_q  <= mem_rdata;
               state <= ST_RE;
            end
            ST_RE: begin
               pop_data <= {mem_rdata, lo_q};
               state    <= ST_IDLE;
               done     <= 1'b1;
            end
            ST_VL: state <= ST_VH;
            ST_VH: begin
               lo_q  <= mem_rdata;
               state <= ST_VE;
            end
            ST_VE: begin
               pc_out <= {mem_rdata, lo_q};
               state  <= ST_IDLE;
               done   <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_no_rw_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));

   assert_dp_only_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dp_base) |-> done);

   assert_cmd_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_q));

endmodule

// File: rtl/stk_call_ctrl.sv
module stk_call_ctrl
   import stk_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SP_W         = 8,
   parameter int SP_RESET     = 'hFF,
   parameter int STACK_PAGE   = 1,
   parameter int VEC_BASE     = 'hFFC0,
   parameter int VEC_N        = 16,
   parameter int PAGE_BASE    = 'hFF00,
   parameter int DP_FLAG_BIT  = 5,
   parameter int DP_HIGH_BASE = 'h0100,
   parameter bit PAGE_WRAP    = 1'b1,
   localparam int ADDR_W      = 2 * DATA_W,
   localparam int IDX_W       = $clog2(VEC_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        cmd,
   input  logic [ADDR_W-1:0] arg,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] psw_in,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] pop_data,
   output logic [SP_W-1:0]   sp,
   output logic [ADDR_W-1:0] dp_base,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (SP_W >= ADDR_W) begin : g_bad_sp
         $error("stk_call_ctrl: SP_W must be narrower than the address");
      end
      if (DP_FLAG_BIT >= DATA_W) begin : g_bad_flag
         $error("stk_call_ctrl: DP_FLAG_BIT outside the status byte");
      end
      if (VEC_BASE + 2 * VEC_N > (1 << ADDR_W)) begin : g_bad_vec
         $error("stk_call_ctrl: vector table exceeds the address space");
      end
      if ((1 << IDX_W) != VEC_N) begin : g_bad_vec_n
         $error("stk_call_ctrl: VEC_N must be a power of two");
      end
   endgenerate

   stk_state_e        state;
   logic [IDX_W-1:0]  vec_idx;
   logic              sp_en;
   logic [SP_W-1:0]   sp_step;

   stk_seq #(
      .DATA_W(DATA_W), .SP_W(SP_W), .VEC_N(VEC_N), .PAGE_BASE(PAGE_BASE),
      .DP_FLAG_BIT(DP_FLAG_BIT), .DP_HIGH_BASE(DP_HIGH_BASE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .arg(arg),
      .pc_in(pc_in), .psw_in(psw_in), .mem_rdata(mem_rdata),
      .state(state), .vec_idx(vec_idx), .sp_en(sp_en), .sp_step(sp_step),
      .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
      .busy(busy), .done(done), .pc_out(pc_out), .pop_data(pop_data),
      .dp_base(dp_base)
   );

   stk_sp #(.SP_W(SP_W), .SP_RESET(SP_W'(SP_RESET))) u_sp (
      .clk(clk), .rst_n(rst_n), .step_en(sp_en), .step(sp_step), .sp(sp)
   );

   stk_addr #(
      .ADDR_W(ADDR_W), .SP_W(SP_W), .STACK_PAGE(STACK_PAGE),
      .VEC_BASE(VEC_BASE), .VEC_N(VEC_N), .PAGE_WRAP(PAGE_WRAP)
   ) u_addr (
      .state(state), .sp(sp), .vec_idx(vec_idx), .mem_addr(mem_addr)
   );

   generate
      if (PAGE_WRAP) begin : g_page_chk
         assert_write_in_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we |-> (mem_addr[ADDR_W-1:SP_W] == (ADDR_W-SP_W)'(STACK_PAGE)));
      end
   endgenerate

   assert_vec_read_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && mem_addr[ADDR_W-1:SP_W] != (ADDR_W-SP_W)'(STACK_PAGE)) |->
         (mem_addr >= ADDR_W'(VEC_BASE) && mem_addr < ADDR_W'(VEC_BASE + 2 * VEC_N)));

endmodule

// File: tb/tb_stk_call_ctrl.sv
`timescale 1ns/1ps
module tb_stk_call_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  cmd = '0;
   logic [15:0] arg = '0, pc_in = '0;
   logic [7:0]  psw_in = '0;
   logic        busy, done, mem_we, mem_re;
   logic [15:0] pc_out, pop_data, dp_base, mem_addr;
   logic [7:0]  sp, mem_wdata;
   logic [7:0]  mem_rdata = '0;

   always #4 clk = ~clk;

   stk_call_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .arg(arg),
      .pc_in(pc_in), .psw_in(psw_in), .busy(busy), .done(done),
      .pc_out(pc_out), .pop_data(pop_data), .sp(sp), .dp_base(dp_base),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_chk = 0, n_fail = 0;
   int wcnt = 0, clash = 0, stray = 0;
   logic [15:0] wa [8];
   logic [7:0]  wd [8];
   logic [7:0]  stk_mem [256];
   logic [7:0]  m_sp = 8'hFF;
   logic [15:0] m_dp = 16'h0000;

   function automatic logic [7:0] vbyte(input logic [15:0] a);
      return a[7:0] ^ 8'hA5;
   endfunction

   function automatic logic [15:0] vec(input int n);
      logic [15:0] lo = 16'hFFC0 + 16'((15 - n) * 2);
      return {vbyte(lo + 16'd1), vbyte(lo)};
   endfunction

   // synchronous memory model
   always @(posedge clk) begin
      if (mem_we && mem_re) clash++;
      if (mem_re) begin
         if (mem_addr[15:8] == 8'h01)      mem_rdata <= stk_mem[mem_addr[7:0]];
         else if (mem_addr >= 16'hFFC0)    mem_rdata <= vbyte(mem_addr);
         else                              mem_rdata <= 8'hEE;
      end
      if (mem_we) begin
         if (wcnt < 8) begin
            wa[wcnt] = mem_addr;
            wd[wcnt] = mem_wdata;
         end
         wcnt++;
         if (mem_addr[15:8] == 8'h01) stk_mem[mem_addr[7:0]] <= mem_wdata;
         else stray++;
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [3:0] c, input logic [15:0] a, input logic [15:0] p,
                        input logic [7:0] s, output int cyc);
      @(negedge clk);
      wcnt = 0;
      cmd = c; arg = a; pc_in = p; psw_in = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic t_reset_state();
      chk("R1", "sp", sp, 8'hFF);
      chk("R1", "dp_base", dp_base, 0);
      chk("R1", "pc_out", pc_out, 0);
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
   endtask

   task automatic t_push_b(input logic [7:0] v);
      int cyc;
      logic [15:0] ea = {8'h01, m_sp};
      do_op(4'd0, {8'h00, v}, 16'h0, 8'h0, cyc);
      m_sp = m_sp - 8'd1;
      chk("R2", "push byte writes", wcnt, 1);
      chk("R2", "push byte addr", wa[0], ea);
      chk("R2", "push byte data", wd[0], v);
      chk("R4", "sp after push byte", sp, m_sp);
      chk("R10", "push byte cycles", cyc, 2);
   endtask

   task automatic t_pop_b(input bit status);
      int cyc;
      logic [7:0] ev;
      m_sp = m_sp + 8'd1;
      ev = stk_mem[m_sp];
      do_op(status ? 4'd4 : 4'd1, 16'h0, 16'h0, 8'h0, cyc);
      if (status) m_dp = ev[5] ? 16'h0100 : 16'h0000;
      chk("R2", "pop byte data", pop_data, {8'h00, ev});
      chk("R4", "sp after pop byte", sp, m_sp);
      chk("R2", "pop byte writes", wcnt, 0);
      chk("R9", "dp_base after pop", dp_base, m_dp);
      chk("R10", "pop byte cycles", cyc, 3);
   endtask

   task automatic t_push_w(input logic [15:0] w);
      int cyc;
      logic [15:0] alo = {8'h01, 8'(m_sp - 8'd1)};
      logic [15:0] ahi = {8'h01, m_sp};
      do_op(4'd2, w, 16'h0, 8'h0, cyc);
      m_sp = m_sp - 8'd2;
      chk("R3", "push word writes", wcnt, 2);
      chk("R4", "push word low addr", wa[0], alo);
      chk("R3", "push word low data", wd[0], w[7:0]);
      chk("R4", "push word high addr", wa[1], ahi);
      chk("R3", "push word high data", wd[1], w[15:8]);
      chk("R3", "sp after push word", sp, m_sp);
      chk("R10", "push word cycles", cyc, 3);
   endtask

   task automatic t_pop_w();
      int cyc;
      logic [15:0] ev;
      ev = {stk_mem[8'(m_sp + 8'd2)], stk_mem[8'(m_sp + 8'd1)]};
      do_op(4'd3, 16'h0, 16'h0, 8'h0, cyc);
      m_sp = m_sp + 8'd2;
      chk("R3", "pop word data", pop_data, ev);
      chk("R4", "sp after pop word", sp, m_sp);
      chk("R10", "pop word cycles", cyc, 4);
   endtask

   task automatic t_call(input logic [3:0] c, input logic [15:0] a, input logic [15:0] p,
                         input logic [15:0] eret, input logic [15:0] epc,
                         input int ecyc, input string req);
      int cyc;
      logic [15:0] alo = {8'h01, 8'(m_sp - 8'd1)};
      logic [15:0] ahi = {8'h01, m_sp};
      do_op(c, a, p, 8'h0, cyc);
      m_sp = m_sp - 8'd2;
      chk(req, "call writes", wcnt, 2);
      chk(req, "return low addr", wa[0], alo);
      chk(req, "return low", wd[0], eret[7:0]);
      chk(req, "return high addr", wa[1], ahi);
      chk(req, "return high", wd[1], eret[15:8]);
      chk(req, "new pc", pc_out, epc);
      chk(req, "sp after call", sp, m_sp);
      chk("R10", "call cycles", cyc, ecyc);
   endtask

   task automatic t_brk(input logic [15:0] p, input logic [7:0] s);
      int cyc;
      logic [15:0] ret = p + 16'd1;
      logic [15:0] alo = {8'h01, 8'(m_sp - 8'd1)};
      logic [15:0] ahi = {8'h01, m_sp};
      logic [15:0] aps = {8'h01, 8'(m_sp - 8'd2)};
      do_op(4'd8, 16'h0, p, s, cyc);
      m_sp = m_sp - 8'd3;
      chk("R8", "break writes", wcnt, 3);
      chk("R8", "break low addr", wa[0], alo);
      chk("R8", "break low", wd[0], ret[7:0]);
      chk("R8", "break high addr", wa[1], ahi);
      chk("R8", "break high", wd[1], ret[15:8]);
      chk("R8", "break status addr", wa[2], aps);
      chk("R8", "break status", wd[2], s);
      chk("R8", "break sp", sp, m_sp);
      chk("R8", "break pc", pc_out, vec(0));
      chk("R10", "break cycles", cyc, 7);
   endtask

   task automatic t_busy_ignore();
      int cyc;
      logic [7:0] sp0;
      @(negedge clk);
      wcnt = 0;
      cmd = 4'd7; arg = 16'h0003; pc_in = 16'h4000; start = 1'b1;
      @(negedge clk);
      cmd = 4'd0; arg = 16'h0077; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
      while (!done && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      m_sp = m_sp - 8'd2;
      chk("R11", "writes with stray start", wcnt, 2);
      chk("R11", "sp with stray start", sp, m_sp);
      chk("R11", "pc with stray start", pc_out, vec(3));
      chk("R11", "cycles with stray start", cyc, 6);
      sp0 = sp;
      repeat (3) @(negedge clk);
      chk("R11", "no late activity writes", wcnt, 2);
      chk("R11", "no late activity sp", sp, sp0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) stk_mem[i] = 8'(i) ^ 8'h3C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();

      t_push_b(8'hA5);
      t_pop_b(1'b0);
      t_pop_b(1'b0);                      // S wraps 0xFF -> 0x00
      chk("R4", "sp wrapped to zero", sp, 8'h00);
      t_push_w(16'h1234);                 // low at 0x01FF, high at 0x0100
      t_pop_w();
      t_pop_w();
      t_push_w(16'hBEEF);

      t_call(4'd5, 16'h8123, 16'h0400, 16'h0403, 16'h8123, 3, "R5");
      t_call(4'd6, 16'h55A7, 16'h2000, 16'h2002, 16'hFFA7, 3, "R6");
      t_call(4'd6, 16'h0010, 16'h2FFE, 16'h3000, 16'hFF10, 3, "R6");
      t_call(4'd7, 16'h0000, 16'h3000, 16'h3001, vec(0), 6, "R7");
      t_call(4'd7, 16'h0005, 16'h3000, 16'h3001, vec(5), 6, "R7");
      t_call(4'd7, 16'h000F, 16'hFFFF, 16'h0000, vec(15), 6, "R7");
      t_brk(16'h1233, 8'h6B);

      t_push_b(8'h20);
      t_pop_b(1'b1);                      // dp -> 0x0100
      t_push_b(8'h20);
      t_pop_b(1'b0);                      // plain pop leaves dp alone
      t_push_b(8'hDF);
      t_pop_b(1'b1);                      // bit 5 clear -> dp 0x0000

      t_busy_ignore();

      chk("R10", "read/write clashes", clash, 0);
      chk("R4", "writes outside stack page", stray, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule